// File: doc/BRIEF.md
# Graphics DRAM Command Sequencer

This block sits on the controller side of a two-bank synchronous graphics DRAM with a 32-bit data bus. It accepts one request at a time from a simple user port. A request is a read or a write, with a bank, row and column, and a flag that asks for the row to be closed by the memory itself. For each request the block emits the command stream on the memory pins: an activate, then the read or write, then the data burst, and then the row-close step. Every cycle that carries no command drives a no-operation code.

The row is closed after every request. Reads that ask for auto-close carry the close bit on the address and then hold the bus silent for the required lockout. All other requests end with an explicit precharge. Burst length and CAS latency are sampled from the configuration inputs when a request is accepted. Write words are pulled from the user in the same cycle that they go onto the data pins. Read words are captured after the programmed latency and handed back with a valid strobe.

Top module: `sgram_seq`

## Requirements
- R1: Out of reset, and whenever `req_ready_o` is high, the pins carry NOP (ras,cas,we = 1,1,1) with `sd_dq_oe_o` low. A request is accepted only on a cycle with `req_valid_i` and `req_ready_o` both high.
- R2: An accepted request first issues ACTIVATE (0,1,1) with the row on `sd_addr_o` and the bank on `sd_ba_o`. The READ or WRITE follows exactly T_RCD cycles after the ACTIVATE.
- R3: WRITE is (1,0,0) with address bit 9 low and the column on `sd_addr_o[7:0]`. The first data word is on `sd_dq_o` with `sd_dq_oe_o` high in the same cycle as the WRITE. One word per cycle follows for the rest of the burst. `wdata_ready_o` is high in exactly the cycles whose `wdata_i` is placed on `sd_dq_o`.
- R4: `sd_dq_oe_o` is low in every cycle outside a write burst.
- R5: READ is (1,0,1) with the column on `sd_addr_o[7:0]`. Address bit 9 is high when `req_autopre_i` was set on the request and low otherwise.
- R6: With CAS latency code L (1, 2 or 3 on `cfg_cas_lat_i`; 0 acts as 1), the word on `sd_dq_i` L+i cycles after the READ is presented on `rdata_o` one cycle later, with `rdata_valid_o` high. `rdata_valid_o` is low in every other cycle.
- R7: `cfg_burst_i` codes 0, 1, 2, 3 and 7 select bursts of 1, 2, 4, 8 and 256 words (full page). Any other code selects 1.
- R8: After a READ with bit 9 high and a burst shorter than a full page, no command other than NOP appears for T_RP plus burst-length cycles, and no PRECHARGE is issued for that request.
- R9: Writes, and reads without auto-close, are followed by PRECHARGE (0,1,0) to the same bank exactly burst-length cycles after the READ or WRITE. The next ACTIVATE comes at least T_RP cycles after the PRECHARGE.
- R10: In full-page mode the burst runs 256 cycles and is ended by an explicit PRECHARGE 256 cycles after the READ or WRITE. This holds even when bit 9 was set on the read, since the memory ignores auto-close in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cas_lat_i | input | 2 | CAS latency code, sampled on accept |
| cfg_burst_i | input | 3 | Burst length code, sampled on accept |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request may be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Ask for memory-side row close on reads |
| req_bank_i | input | 1 | Bank select |
| req_row_i | input | 11 | Row address |
| req_col_i | input | 8 | Start column |
| wdata_i | input | 32 | Write word for the current beat |
| wdata_ready_o | output | 1 | `wdata_i` is consumed this cycle |
| rdata_o | output | 32 | Returned read word |
| rdata_valid_o | output | 1 | `rdata_o` holds a new read word |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_dsf_o | output | 1 | Special-function select, held low |
| sd_ba_o | output | 1 | Bank address |
| sd_addr_o | output | 11 | Row / column address, bit 9 = auto-close |
| sd_dq_o | output | 32 | Write data to the pads |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | 32 | Read data from the pads |

## Verification
The bench varies the latency between 1 and 3 across back-to-back reads. A design that tapped its read pipeline with the latency of the newest request would shift or drop words and fail the per-cycle valid check. Full-page reads with the close bit set are aimed at a design that trusts the memory to close the row. Such a design skips the precharge, and the bench sees no PRECHARGE at the 256th cycle. Odd start columns with bursts of 8, and the reserved burst codes, expose wrong beat counts, which show up as a PRECHARGE on the wrong cycle or as the output enable staying high. Write-then-read round trips catch a data word driven one cycle late relative to the WRITE.

// File: rtl/sgram_seq_pkg.sv
package sgram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_BURST, ST_PRE, ST_WAIT
  } seq_state_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP   = 3'b111;
  localparam logic [2:0] CMD_ACT   = 3'b011;
  localparam logic [2:0] CMD_READ  = 3'b101;
  localparam logic [2:0] CMD_WRITE = 3'b100;
  localparam logic [2:0] CMD_PRE   = 3'b010;

  function automatic int unsigned burst_beats(input logic [2:0] code, input int unsigned page);
    case (code)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      3'd7:    return page;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sgram_seq_fsm.sv
module sgram_seq_fsm
  import sgram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_RP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_autopre_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [2:0]        cfg_burst_i,
  input  logic [1:0]        cfg_cas_lat_i,
  output logic              req_ready_o,
  output seq_state_e        state_o,
  output logic              first_beat_o,
  output logic              write_o,
  output logic              autopre_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [1:0]        cl_idx_o
);
  localparam int unsigned PAGE   = 1 << COL_W;
  localparam int unsigned BEAT_W = COL_W + 1;
  localparam int unsigned T_MAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1) + 1;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] beat_q, blen_q;
  logic              full_q, wr_q, ap_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [1:0]        cl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      blen_q  <= BEAT_W'(1);
      full_q  <= 1'b0;
      wr_q    <= 1'b0;
      ap_q    <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      cl_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          ap_q    <= req_autopre_i;
          bank_q  <= req_bank_i;
          row_q   <= req_row_i;
          col_q   <= req_col_i;
          blen_q  <= BEAT_W'(burst_beats(cfg_burst_i, PAGE));
          full_q  <= (burst_beats(cfg_burst_i, PAGE) == PAGE);
          cl_q    <= (cfg_cas_lat_i == 2'd0) ? 2'd0 : cfg_cas_lat_i - 2'd1;
          state_q <= ST_ACT;
        end
        ST_ACT: begin
          beat_q <= '0;
          if (T_RCD > 1) begin
            cnt_q   <= CNT_W'(T_RCD - 2);
            state_q <= ST_RCD;
          end else begin
            state_q <= ST_BURST;
          end
        end
        ST_RCD: begin
          if (cnt_q == '0) state_q <= ST_BURST;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_BURST: begin
          if (beat_q == blen_q - 1'b1) begin
            // memory closes the row itself only for short auto-close reads
            if (!wr_q && ap_q && !full_q) begin
              cnt_q   <= CNT_W'(T_RP - 1);
              state_q <= ST_WAIT;
            end else begin
              state_q <= ST_PRE;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_PRE: begin
          cnt_q   <= CNT_W'(T_RP - 1);
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign state_o      = state_q;
  assign first_beat_o = (state_q == ST_BURST) && (beat_q == '0);
  assign write_o      = wr_q;
  assign autopre_o    = ap_q;
  assign bank_o       = bank_q;
  assign row_o        = row_q;
  assign col_o        = col_q;
  assign cl_idx_o     = cl_q;
endmodule

// File: rtl/sgram_seq_cmd.sv
module sgram_seq_cmd
  import sgram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned AP_BIT = 9
) (
  input  seq_state_e        state_i,
  input  logic              first_beat_i,
  input  logic              write_i,
  input  logic              autopre_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);
  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    case (state_i)
      ST_ACT: begin
        cmd_o  = CMD_ACT;
        ba_o   = bank_i;
        addr_o = row_i;
      end
      ST_BURST: if (first_beat_i) begin
        cmd_o              = write_i ? CMD_WRITE : CMD_READ;
        ba_o               = bank_i;
        addr_o[COL_W-1:0]  = col_i;
        addr_o[AP_BIT]     = !write_i && autopre_i;
      end
      ST_PRE: begin
        cmd_o = CMD_PRE;
        ba_o  = bank_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sgram_seq_rdpipe.sv
module sgram_seq_rdpipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_beat_i,
  input  logic [1:0]        cl_idx_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic [MAX_CL-1:0] pipe_q, pipe_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  // inject at the latency slot so in-flight beats keep their own latency
  always_comb begin
    pipe_d = pipe_q >> 1;
    if (rd_beat_i) pipe_d[cl_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      pipe_q  <= pipe_d;
      valid_q <= pipe_q[0];
      if (pipe_q[0]) data_q <= dq_i;
    end
  end

  assign rdata_o       = data_q;
  assign rdata_valid_o = valid_q;
endmodule

// File: rtl/sgram_seq.sv
module sgram_seq
  import sgram_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned AP_BIT = 9,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_RP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_cas_lat_i,
  input  logic [2:0]        cfg_burst_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_autopre_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic              sd_dsf_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DATA_W-1:0] sd_dq_i
);
  seq_state_e        state;
  logic              first_beat, wr, ap;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [1:0]        cl_idx;
  logic [2:0]        cmd;
  logic              in_burst;

  sgram_seq_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RP(T_RP)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_autopre_i,
    .req_bank_i, .req_row_i, .req_col_i, .cfg_burst_i, .cfg_cas_lat_i,
    .req_ready_o,
    .state_o(state), .first_beat_o(first_beat), .write_o(wr), .autopre_o(ap),
    .bank_o(bank), .row_o(row), .col_o(col), .cl_idx_o(cl_idx)
  );

  sgram_seq_cmd #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
  ) u_cmd (
    .state_i(state), .first_beat_i(first_beat), .write_i(wr), .autopre_i(ap),
    .bank_i(bank), .row_i(row), .col_i(col),
    .cmd_o(cmd), .ba_o(sd_ba_o), .addr_o(sd_addr_o)
  );

  assign in_burst = (state == ST_BURST);

  sgram_seq_rdpipe #(.DATA_W(DATA_W), .MAX_CL(3)) u_rd (
    .clk_i, .rst_ni,
    .rd_beat_i(in_burst && !wr), .cl_idx_i(cl_idx), .dq_i(sd_dq_i),
    .rdata_o, .rdata_valid_o
  );

  assign {sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;
  assign sd_dsf_o      = 1'b0;
  assign wdata_ready_o = in_burst && wr;
  assign sd_dq_oe_o    = in_burst && wr;
  assign sd_dq_o       = wdata_i;
endmodule

// File: rtl/sgram_seq_chk.sv
module sgram_seq_chk #(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned AP_BIT = 9,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_RP   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             dq_oe,
  input logic             ready
);
  logic [2:0] cmd;
  logic [7:0] since_act_q, since_pre_q;
  assign cmd = {ras_n, cas_n, we_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= 8'hff;
      since_pre_q <= 8'hff;
    end else begin
      if (cmd == 3'b011)            since_act_q <= 8'd1;
      else if (since_act_q != 8'hff) since_act_q <= since_act_q + 8'd1;
      if (cmd == 3'b010)            since_pre_q <= 8'd1;
      else if (since_pre_q != 8'hff) since_pre_q <= since_pre_q + 8'd1;
    end
  end

  AST_IDLE_IS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> (cmd == 3'b111) && !dq_oe); // R1
  AST_RCD_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n && ras_n) |-> (int'(since_act_q) >= T_RCD)); // R2
  AST_WRITE_AP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 3'b100) |-> !addr[AP_BIT]); // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 3'b100) |-> dq_oe); // R3
  AST_OE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 3'b010) |-> !dq_oe); // R4
  AST_RP_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 3'b011) |-> (int'(since_pre_q) >= T_RP)); // R9
endmodule

bind sgram_seq sgram_seq_chk #(
  .ROW_W(ROW_W), .AP_BIT(AP_BIT), .T_RCD(T_RCD), .T_RP(T_RP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n(sd_ras_n_o), .cas_n(sd_cas_n_o),
  .we_n(sd_we_n_o), .addr(sd_addr_o), .dq_oe(sd_dq_oe_o), .ready(req_ready_o)
);

// File: tb/tb_sgram_seq.sv
module tb_sgram_seq;
  localparam int T_RCD = 2;
  localparam int T_RP  = 2;
  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010;

  logic clk = 0, rst_ni = 0;
  logic [1:0] cfg_cl = 2'd1;
  logic [2:0] cfg_bl = 3'd2;
  logic req_valid = 0, req_write = 0, req_ap = 0, req_bank = 0;
  logic [10:0] req_row = 0;
  logic [7:0] req_col = 0;
  logic [31:0] wdata = 0, sd_dq_i = 0;
  logic req_ready, wdata_ready, rdata_valid;
  logic [31:0] rdata, sd_dq_o;
  logic ras_n, cas_n, we_n, dsf, ba, dq_oe;
  logic [10:0] addr;

  sgram_seq dut (
    .clk_i(clk), .rst_ni, .cfg_cas_lat_i(cfg_cl), .cfg_burst_i(cfg_bl),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_autopre_i(req_ap), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .wdata_i(wdata), .wdata_ready_o(wdata_ready),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid), .sd_ras_n_o(ras_n),
    .sd_cas_n_o(cas_n), .sd_we_n_o(we_n), .sd_dsf_o(dsf), .sd_ba_o(ba),
    .sd_addr_o(addr), .sd_dq_o(sd_dq_o), .sd_dq_oe_o(dq_oe), .sd_dq_i(sd_dq_i)
  );

  always #2 clk = ~clk;

  int total = 0, failed = 0, cyc = 0;
  bit done = 0;
  logic [31:0] mem [int];
  bit          sv [512];
  logic [31:0] sd [512];
  logic [31:0] wlog [$];
  logic [31:0] rlog [$];
  int last_act = -1000, last_pre = -1000, lock_until = 0, pre_due = -1;
  int bstart = -1000, blen_now = 0;
  bit bwr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int bl_of(input logic [2:0] c);
    case (c) 3'd1: return 2; 3'd2: return 4; 3'd3: return 8; 3'd7: return 256; default: return 1; endcase
  endfunction
  function automatic int cl_of(input logic [1:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction
  function automatic int col_at(input int start, input int i, input int bl);
    if (bl == 256) return (start + i) % 256;
    return (start & ~(bl - 1)) | ((start + i) & (bl - 1));
  endfunction
  function automatic int key(input int b, input int r, input int c);
    return (b << 19) | (r << 8) | c;
  endfunction

  // drive data inputs just after the edge
  always @(posedge clk) begin
    cyc++;
    #1;
    sd_dq_i = sv[cyc % 512] ? sd[cyc % 512] : 32'h0;
    if (wdata_ready) begin
      wdata = $urandom;
      wlog.push_back(wdata);
    end else wdata = 32'h0;
  end

  // pin monitor and device model
  always @(negedge clk) if (rst_ni && !done) begin
    logic [2:0] cmd;
    int prev, bl;
    bit in_wr;
    cmd = {ras_n, cas_n, we_n};
    if (req_ready) chk(cmd == NOP && !dq_oe, "R1", cmd, NOP);
    if (cmd != NOP) chk(cyc >= lock_until, "R8", cyc, lock_until);
    if (cmd == PRE || cyc == pre_due)
      chk(cmd == PRE && cyc == pre_due, (blen_now == 256) ? "R10" : "R9", cyc, pre_due);
    case (cmd)
      ACT: begin
        chk(cyc - last_pre >= T_RP, "R9", cyc - last_pre, T_RP);
        chk(addr == req_row && ba == req_bank, "R2", {ba, addr}, {req_bank, req_row});
        last_act = cyc;
      end
      RD, WR: begin
        bl = bl_of(cfg_bl);
        chk(cyc - last_act == T_RCD, "R2", cyc - last_act, T_RCD);
        chk(addr[7:0] == req_col && ba == req_bank, "R3", addr[7:0], req_col);
        chk((cmd == WR) == req_write, "R5", cmd, req_write ? WR : RD);
        if (cmd == WR) chk(addr[9] == 1'b0, "R3", addr[9], 0);
        else           chk(addr[9] == req_ap, "R5", addr[9], req_ap);
        bstart = cyc; blen_now = bl; bwr = (cmd == WR);
        if (cmd == RD) begin
          for (int i = 0; i < bl; i++) begin
            int t, k;
            t = (cyc + cl_of(cfg_cl) + i) % 512;
            k = key(req_bank, req_row, col_at(req_col, i, bl));
            sv[t] = 1;
            sd[t] = mem.exists(k) ? mem[k] : (32'hD00D0000 ^ k);
          end
        end
        if (cmd == RD && req_ap && bl != 256) begin
          lock_until = cyc + T_RP + bl; pre_due = -1;
        end else pre_due = cyc + bl;
      end
      PRE: begin
        chk(ba == req_bank, "R9", ba, req_bank);
        last_pre = cyc; pre_due = -1;
      end
      default: ;
    endcase
    in_wr = bwr && cyc >= bstart && cyc < bstart + blen_now;
    chk(dq_oe == in_wr, "R4", dq_oe, in_wr);
    chk(wdata_ready == in_wr, "R3", wdata_ready, in_wr);
    if (in_wr) begin
      chk(sd_dq_o == wdata, "R3", sd_dq_o, wdata);
      mem[key(req_bank, req_row, col_at(req_col, cyc - bstart, blen_now))] = sd_dq_o;
    end
    prev = (cyc + 511) % 512;
    chk(rdata_valid == sv[prev], "R6", rdata_valid, sv[prev]);
    if (sv[prev]) chk(rdata == sd[prev], "R6", rdata, sd[prev]);
    if (rdata_valid) rlog.push_back(rdata);
    sv[prev] = 0;
  end

  task automatic issue(input bit w, input bit ap, input bit b, input int row, input int col,
                       input int cl, input int blc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_cl = 2'(cl); cfg_bl = 3'(blc);
    req_write = w; req_ap = ap; req_bank = b; req_row = 11'(row); req_col = 8'(col);
    req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic roundtrip(input int cl, input int blc, input bit ap, input int col, input string tag);
    int w0, r0, n;
    n = bl_of(3'(blc));
    w0 = wlog.size(); r0 = rlog.size();
    issue(1, 0, 1, 77, col, cl, blc);
    issue(0, ap, 1, 77, col, cl, blc);
    chk(wlog.size() - w0 == n, tag, wlog.size() - w0, n);
    chk(rlog.size() - r0 == n, "R6", rlog.size() - r0, n);
    for (int i = 0; i < n && (r0 + i) < rlog.size() && (w0 + i) < wlog.size(); i++)
      if (rlog[r0 + i] != wlog[w0 + i] || i == 0)
        chk(rlog[r0 + i] == wlog[w0 + i], tag, rlog[r0 + i], wlog[w0 + i]);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(req_ready && {ras_n, cas_n, we_n} == NOP && !dq_oe && !rdata_valid && !dsf,
        "R1", {ras_n, cas_n, we_n}, NOP);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    roundtrip(1, 2, 0, 1, "R3");
    roundtrip(2, 2, 1, 6, "R3");
    roundtrip(3, 3, 1, 13, "R7");
    roundtrip(0, 0, 0, 200, "R7");
    roundtrip(2, 5, 1, 9, "R7");
    roundtrip(3, 7, 1, 250, "R10");
    roundtrip(1, 7, 0, 3, "R10");
    for (int n = 0; n < 60; n++) begin
      logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6};
      issue($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
            int'($urandom_range(1, 3)), int'(codes[$urandom_range(0, 4)]));
    end
    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule